// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache between a single-word request port and a next-level memory that moves whole blocks. Each word address splits into a word offset, a set index and a tag. The tag is compared against both ways of the selected set in the cycle the request is accepted. On a hit, a read returns the addressed word and a write updates it and marks the line dirty. The response appears one cycle later, and the port can take a new request in every cycle while hits continue.

On a miss, the port stops accepting requests. The cache picks the least recently used way of the set as the victim. If that line is dirty, the cache first writes the whole block to the next level. It then requests the missing block, installs it and returns the requested word. A write miss allocates the block and merges the write word into it as it is installed. The line is then valid and dirty, and the written word is returned.

Requests and memory transfers use valid/ready handshakes. Only one miss is outstanding at a time.

Top module: `sa_wb_cache`

## Requirements
- R1: A word address splits as offset = addr[1:0], set = addr[4:2] and tag = addr[9:5]. Every memory request carries the block-aligned word address {tag, set, 2'b00}.
- R2: A request whose tag matches a valid way of its set is a hit. Its response (resp_valid high) appears in the cycle after acceptance, and a hit issues no memory request.
- R3: A read response carries the most recently written value of the addressed word, taken from the block at the offset. A write response carries the written word.
- R4: A write hit updates the stored word and marks the line dirty, so a later eviction writes the updated block back.
- R5: An access to a way makes it the most recently used way of its set. A miss replaces the least recently used way.
- R6: If the victim is dirty, its whole block is written to memory (mem_req_write=1) at the victim's own block address, and this completes before the refill request is issued.
- R7: A refilled line is installed valid and most recently used. It is clean after a read miss, and a later eviction of a clean line causes no write-back. After a write miss it holds the merged write word and is dirty.
- R8: req_ready is low from the cycle after a missing request is accepted until the refill data arrives. The response appears in the cycle after mem_resp_valid is seen.
- R9: After reset, req_ready=1, resp_valid=0 and mem_req_valid=0, and every line is invalid.
- R10: A memory request that is not accepted keeps mem_req_valid, mem_req_write and mem_req_addr unchanged until mem_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Response word |
| mem_req_valid | output | 1 | Block request to the next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_addr | output | 10 | Block-aligned word address |
| mem_wdata | output | 128 | Write-back block, word 0 in the low bits |
| mem_resp_valid | input | 1 | Refill block present |
| mem_rdata | input | 128 | Refill block, word 0 in the low bits |

## Verification
Two functions can fall in the same cycle. The response of one request (a refill completion or a hit) is presented in the same cycle as the acceptance and tag lookup of the next request. The bench issues every request in the cycle the previous response is seen, so lookups run back to back. The bench also targets the set that was just refilled, so the lookup must see the freshly installed tag, data and recency bit. Each response word is judged against a flat model of memory contents. Each write-back is judged against a model of tags, dirty bits and recency. A stale victim choice or a lost write therefore shows up as a wrong word, a missing or extra write-back, or a wrong address.

// File: rtl/sa_cache_pkg.sv
// Shared types for the two-way write-back cache.
// Assumes a fixed associativity of two, which a single recency bit covers.
package sa_cache_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } miss_state_e;
endpackage

// File: rtl/sa_tag_store.sv
// Tag, valid, dirty and recency storage with a parallel tag compare.
// Assumes that at most one of touch or fill is active in a cycle.
// lru_q[s] names the least recently used way of set s.
module sa_tag_store
    import sa_cache_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             dirty_en,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic             fill_dirty,
    output logic             hit,
    output logic             hit_way,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic             lru_q   [SETS];
    logic [WAYS-1:0]  hit_vec;

    // Compare the looked-up tag against every way of the set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    assign hit       = |hit_vec;
    assign hit_way   = hit_vec[1];
    assign vic_way   = lru_q[lk_idx];
    assign vic_dirty = valid_q[lk_idx][vic_way] && dirty_q[lk_idx][vic_way];
    assign vic_tag   = tag_q[lk_idx][vic_way];

    // Update line state on hits and refills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lru_q[s]   <= 1'b0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else if (fill_en) begin
            tag_q[lk_idx][fill_way]   <= lk_tag;
            valid_q[lk_idx][fill_way] <= 1'b1;
            dirty_q[lk_idx][fill_way] <= fill_dirty;
            lru_q[lk_idx]             <= ~fill_way;
        end else if (touch_en) begin
            lru_q[lk_idx] <= ~touch_way;
            if (dirty_en) dirty_q[lk_idx][touch_way] <= 1'b1;
        end
    end

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
    // R5
    touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> lru_q[$past(lk_idx)] != $past(touch_way));
    // R7
    fill_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(lk_idx)][$past(fill_way)] && lru_q[$past(lk_idx)] != $past(fill_way));
endmodule

// File: rtl/sa_data_store.sv
// Block storage for all ways: one combinational block read port, and one
// write port that takes either a single word or a whole block (the block wins).
// Contents are not reset; the valid bits in the tag store guard them.
module sa_data_store
    import sa_cache_pkg::*;
#(
    parameter int SETS        = 8,
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 4,
    localparam int IDX_W   = $clog2(SETS),
    localparam int OFF_W   = $clog2(BLOCK_WORDS),
    localparam int BLOCK_W = WORD_W * BLOCK_WORDS
) (
    input  logic               clk,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               rd_way,
    output logic [BLOCK_W-1:0] rd_block,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_way,
    input  logic               word_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               block_en,
    input  logic [BLOCK_W-1:0] wr_block
);
    logic [BLOCK_W-1:0] blk_q [SETS][WAYS];

    assign rd_block = blk_q[rd_idx][rd_way];

    // Write a refilled block or a single word
    always_ff @(posedge clk) begin
        if (block_en) blk_q[wr_idx][wr_way] <= wr_block;
        else if (word_en) blk_q[wr_idx][wr_way][wr_off*WORD_W +: WORD_W] <= wr_word;
    end
endmodule

// File: rtl/sa_miss_fsm.sv
// Miss sequencer: optional write-back, refill request, then wait for data.
// Assumes start_miss is raised only while idle.
module sa_miss_fsm
    import sa_cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_miss,
    input  logic        vic_dirty,
    input  logic        mem_req_ready,
    input  logic        mem_resp_valid,
    output miss_state_e state
);
    miss_state_e nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_miss) nxt = vic_dirty ? ST_WBACK : ST_FETCH;
            ST_WBACK: if (mem_req_ready) nxt = ST_FETCH;
            ST_FETCH: if (mem_req_ready) nxt = ST_WAIT;
            ST_WAIT:  if (mem_resp_valid) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R6
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK && mem_req_ready) |=> state == ST_FETCH);
    // R8
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_resp_valid) |=> state == ST_IDLE);
endmodule

// File: rtl/sa_wb_cache.sv
// Two-way set-associative write-back cache with word requests and block memory.
// Looks up tags combinationally while idle, so hits respond one cycle after
// acceptance. Misses block the request port until the refill is installed.
module sa_wb_cache
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int WORD_W      = 32,
    parameter int SETS        = 8,
    parameter int BLOCK_WORDS = 4,
    localparam int OFF_W   = $clog2(BLOCK_WORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int BLOCK_W = WORD_W * BLOCK_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_rdata,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [BLOCK_W-1:0] mem_wdata,
    input  logic               mem_resp_valid,
    input  logic [BLOCK_W-1:0] mem_rdata
);
    miss_state_e        state;
    logic               idle, accept, acc_hit, acc_miss, fill_en;
    logic [OFF_W-1:0]   r_off, m_off;
    logic [IDX_W-1:0]   r_idx, m_idx, lk_idx;
    logic [TAG_W-1:0]   r_tag, m_tag, lk_tag, vic_tag;
    logic [ADDR_W-1:0]  m_addr_q;
    logic               m_wr_q;
    logic [WORD_W-1:0]  m_wdata_q;
    logic               hit, hit_way, vic_way, vic_dirty, rd_way;
    logic [BLOCK_W-1:0] rd_block, fill_block;

    assign {r_tag, r_idx, r_off} = req_addr;
    assign {m_tag, m_idx, m_off} = m_addr_q;

    assign idle      = (state == ST_IDLE);
    assign req_ready = idle;
    assign accept    = req_valid && req_ready;
    assign acc_hit   = accept && hit;
    assign acc_miss  = accept && !hit;
    assign fill_en   = (state == ST_WAIT) && mem_resp_valid;
    assign lk_idx    = idle ? r_idx : m_idx;
    assign lk_tag    = idle ? r_tag : m_tag;
    assign rd_way    = idle ? hit_way : vic_way;

    // Capture the missing request for the duration of the miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_addr_q  <= '0;
            m_wr_q    <= 1'b0;
            m_wdata_q <= '0;
        end else if (acc_miss) begin
            m_addr_q  <= req_addr;
            m_wr_q    <= req_write;
            m_wdata_q <= req_wdata;
        end
    end

    // Merge a pending write word into the refilled block
    always_comb begin
        fill_block = mem_rdata;
        if (m_wr_q) fill_block[m_off*WORD_W +: WORD_W] = m_wdata_q;
    end

    sa_miss_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_miss     (acc_miss),
        .vic_dirty      (vic_dirty),
        .mem_req_ready  (mem_req_ready),
        .mem_resp_valid (mem_resp_valid),
        .state          (state)
    );

    sa_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .touch_en   (acc_hit),
        .touch_way  (hit_way),
        .dirty_en   (acc_hit && req_write),
        .fill_en    (fill_en),
        .fill_way   (vic_way),
        .fill_dirty (m_wr_q),
        .hit        (hit),
        .hit_way    (hit_way),
        .vic_way    (vic_way),
        .vic_dirty  (vic_dirty),
        .vic_tag    (vic_tag)
    );

    sa_data_store #(.SETS(SETS), .WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS)) u_data (
        .clk      (clk),
        .rd_idx   (lk_idx),
        .rd_way   (rd_way),
        .rd_block (rd_block),
        .wr_idx   (lk_idx),
        .wr_way   (rd_way),
        .word_en  (acc_hit && req_write),
        .wr_off   (r_off),
        .wr_word  (req_wdata),
        .block_en (fill_en),
        .wr_block (fill_block)
    );

    assign mem_req_valid = (state == ST_WBACK) || (state == ST_FETCH);
    assign mem_req_write = (state == ST_WBACK);
    assign mem_req_addr  = (state == ST_WBACK) ? {vic_tag, m_idx, {OFF_W{1'b0}}}
                                               : {m_tag, m_idx, {OFF_W{1'b0}}};
    assign mem_wdata     = rd_block;

    // Register the response word for hits and completed refills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= acc_hit || fill_en;
            if (acc_hit)
                resp_rdata <= req_write ? req_wdata : rd_block[r_off*WORD_W +: WORD_W];
            else if (fill_en)
                resp_rdata <= fill_block[m_off*WORD_W +: WORD_W];
        end
    end

    // R2
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_hit |=> resp_valid);
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> !req_ready);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
    // R8
    fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) fill_en |=> resp_valid);
endmodule

// File: tb/sim_sa_wb_cache.sv
module sim_sa_wb_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
    logic [9:0]   mem_req_addr;
    logic [127:0] mem_wdata, mem_rdata = '0;

    always #4 clk = ~clk;

    sa_wb_cache u0 (.*);

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] gmem [1024];
    logic [31:0] bmem [1024];
    logic [4:0]  mtag [8][2];
    bit          mval [8][2];
    bit          mdirty [8][2];
    bit          mlru [8];
    int wb_cnt = 0, fetch_cnt = 0, seq = 0, wb_seq = 0, fetch_seq = 0;
    logic [9:0]   last_wb_addr, last_fetch_addr, pend_addr;
    logic [127:0] last_wb_data;
    bit pend = 1'b0;
    int dly = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] gblock(input logic [9:0] base);
        logic [127:0] b;
        for (int i = 0; i < 4; i++) b[i*32 +: 32] = gmem[base + 10'(i)];
        return b;
    endfunction

    // Next-level memory model, acting at falling edges
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready  = 1'b0;
            mem_resp_valid = 1'b0;
        end else begin
            mem_resp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_resp_valid = 1'b1;
                    for (int i = 0; i < 4; i++) mem_rdata[i*32 +: 32] = bmem[pend_addr + 10'(i)];
                    pend = 1'b0;
                end else dly--;
            end
            mem_req_ready = ($urandom % 3) != 0;
            if (mem_req_valid && mem_req_ready) begin
                seq++;
                if (mem_req_write) begin
                    wb_cnt++;
                    wb_seq = seq;
                    last_wb_addr = mem_req_addr;
                    last_wb_data = mem_wdata;
                    for (int i = 0; i < 4; i++) bmem[mem_req_addr + 10'(i)] = mem_wdata[i*32 +: 32];
                end else begin
                    fetch_cnt++;
                    fetch_seq = seq;
                    last_fetch_addr = mem_req_addr;
                    pend = 1'b1;
                    pend_addr = mem_req_addr;
                    dly = $urandom % 3;
                end
            end
        end
    end

    // Issue one request at the current falling edge; return at the edge where its response shows
    task automatic do_req(input bit w, input logic [9:0] a, input logic [31:0] d);
        logic [2:0]  idx = a[4:2];
        logic [4:0]  tg = a[9:5];
        int          hw = -1;
        bit          vw, exp_wb, rdy_bad = 1'b0;
        logic [9:0]  wb_a;
        logic [31:0] exp_d;
        int          wb0 = wb_cnt, f0 = fetch_cnt, cyc = 0;
        for (int k = 0; k < 2; k++) if (mval[idx][k] && mtag[idx][k] == tg) hw = k;
        vw     = mlru[idx];
        exp_wb = (hw < 0) && mval[idx][vw] && mdirty[idx][vw];
        wb_a   = {mtag[idx][vw], idx, 2'b00};
        exp_d  = w ? d : gmem[a];
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && cyc < 300) begin
            if (req_ready) rdy_bad = 1'b1;
            @(negedge clk);
            cyc++;
        end
        chk(resp_valid, "R8 response arrives", 128'(resp_valid), 128'd1);
        chk(resp_rdata == exp_d, "R3 response word", 128'(resp_rdata), 128'(exp_d));
        if (hw >= 0) begin
            chk(cyc == 0, "R2 hit latency", 128'(cyc), 128'd0);
            chk(wb_cnt == wb0 && fetch_cnt == f0, "R2 no memory traffic on hit",
                128'(wb_cnt - wb0 + fetch_cnt - f0), 128'd0);
        end else begin
            chk(!rdy_bad, "R8 ready low during miss", 128'(rdy_bad), 128'd0);
            chk(fetch_cnt == f0 + 1, "R2 one refill per miss", 128'(fetch_cnt - f0), 128'd1);
            chk(last_fetch_addr == {a[9:2], 2'b00}, "R1 refill block address",
                128'(last_fetch_addr), 128'({a[9:2], 2'b00}));
            chk(wb_cnt == wb0 + int'(exp_wb), exp_wb ? "R6 dirty victim written back" : "R7 clean victim not written",
                128'(wb_cnt - wb0), 128'(exp_wb));
            if (exp_wb) begin
                chk(last_wb_addr == wb_a, "R5 victim is least recently used", 128'(last_wb_addr), 128'(wb_a));
                chk(last_wb_data == gblock(wb_a), "R4 written-back block", last_wb_data, gblock(wb_a));
                chk(wb_seq < fetch_seq, "R6 write-back before refill", 128'(wb_seq), 128'(fetch_seq));
            end
        end
        if (hw >= 0) begin
            mlru[idx] = (hw == 0);
            if (w) mdirty[idx][hw] = 1'b1;
        end else begin
            mtag[idx][vw] = tg; mval[idx][vw] = 1'b1; mdirty[idx][vw] = w; mlru[idx] = ~vw;
        end
        if (w) gmem[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            gmem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
            bmem[i] = gmem[i];
        end
        for (int s = 0; s < 8; s++) begin
            mlru[s] = 1'b0;
            for (int k = 0; k < 2; k++) begin mval[s][k] = 1'b0; mdirty[s][k] = 1'b0; mtag[s][k] = '0; end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9 ready after reset", 128'(req_ready), 128'd1);
        chk(resp_valid == 1'b0, "R9 no response after reset", 128'(resp_valid), 128'd0);
        chk(mem_req_valid == 1'b0, "R9 no memory request after reset", 128'(mem_req_valid), 128'd0);
        // Directed: fill set 3 with tags 1 and 2 dirty, touch tag 1, then conflict with tag 3 (R5, R6)
        do_req(1'b1, {5'd1, 3'd3, 2'd0}, 32'hAAAA0001);
        do_req(1'b1, {5'd2, 3'd3, 2'd1}, 32'hBBBB0002);
        do_req(1'b0, {5'd1, 3'd3, 2'd0}, 32'h0);
        do_req(1'b0, {5'd3, 3'd3, 2'd2}, 32'h0);
        do_req(1'b0, {5'd2, 3'd3, 2'd1}, 32'h0);
        // Directed: write miss then immediate read of the same and neighbour words (R7, R3)
        do_req(1'b1, {5'd7, 3'd5, 2'd3}, 32'hC0DE0007);
        do_req(1'b0, {5'd7, 3'd5, 2'd3}, 32'h0);
        do_req(1'b0, {5'd7, 3'd5, 2'd0}, 32'h0);
        // Directed: clean eviction in a set of clean lines (R7)
        do_req(1'b0, {5'd4, 3'd6, 2'd0}, 32'h0);
        do_req(1'b0, {5'd5, 3'd6, 2'd0}, 32'h0);
        do_req(1'b0, {5'd6, 3'd6, 2'd0}, 32'h0);
        // Random traffic over few tags to force conflicts, back to back
        for (int n = 0; n < 1500; n++) begin
            logic [9:0] a;
            a = {5'($urandom % 4), 3'($urandom % 8), 2'($urandom % 4)};
            do_req(($urandom % 2) == 1, a, $urandom);
            if ($urandom % 8 == 0) @(negedge clk);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule